// File: doc/BRIEF.md
# Double-Buffered Serial DAC Input Front End

This block is the digital front end of a 16-bit voltage-output converter. A host shifts a code word in over a three-wire serial link. The link has an active-low frame select, a serial clock and a data line. The block keeps the word in an input register. It then moves the word into the DAC register that drives the converter core. The transfer happens either at the end of the frame or later, when a separate active-low load strobe falls. An active-low clear input acts on its falling edge and forces both registers to a code picked by a strap. While clear stays low, every load request is ignored.

All serial pins are synchronized into one faster system clock, and their edges are detected in that domain. The DAC register leaves the block in two forms: the plain 16-bit code, and a segmented form for a resistor-string core. The segmented form has the four MSBs decoded into 15 equal-weight thermometer enables and the low 12 bits passed on as binary ladder switches. A one-cycle pulse marks each frame end and reports whether the frame carried a full word.

Top module: `dacFrontEnd`

## Requirements
- R1: While csN is low, each rising edge of sclk shifts din into the shift register, MSB first. With ldacN held low, a 16-bit frame appears on dacCode after csN rises.
- R2: Rising edges of sclk while csN is high leave the shift register unchanged. A frame with no clock edges then reloads the previous word.
- R3: When more than 16 bits arrive in one frame, only the last 16 are kept.
- R4: When n < 16 bits arrive, the result is the previous word shifted up by n, with the new bits in the n LSBs.
- R5: With ldacN high during a frame, dacCode is unchanged at the rise of csN. A later falling edge on ldacN copies the input register into the DAC register.
- R6: A falling edge on clrN sets both the input register and the DAC register to 0x8000 when midClr is 1, or to 0x0000 when midClr is 0.
- R7: While clrN is low, no ldacN edge and no frame end changes dacCode. A frame received in that time still loads the input register.
- R8: After power-on reset, dacCode, segTherm, ladderBits and frameDone are all zero.
- R9: segTherm has exactly k bits set, at indices 0 to k-1, where k = dacCode[15:12]. ladderBits equals dacCode[11:0].
- R10: frameDone is high for exactly one clock per rising edge of csN. frameFull is high with it exactly when at least 16 sclk rising edges came in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sclk |
| rstN | input | 1 | Active-low power-on reset |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| din | input | 1 | Serial data, MSB first |
| ldacN | input | 1 | Active-low load strobe for the DAC register |
| clrN | input | 1 | Active-low clear, acts on its falling edge |
| midClr | input | 1 | Strap: 1 clears to midscale, 0 to zero-scale |
| dacCode | output | 16 | DAC register contents |
| segTherm | output | 15 | Thermometer enables from the 4 MSBs |
| ladderBits | output | 12 | Binary ladder switches, the 12 LSBs |
| frameDone | output | 1 | One-cycle pulse at each frame end |
| frameFull | output | 1 | Frame had at least 16 bits, valid with frameDone |

## Verification
The bench runs full 16-bit frames whose top nibble sweeps all 16 values. This separates every thermometer count and checks that the low 12 bits pass through untouched. Overlong frames and short frames tell apart keeping the last bits from keeping the first bits, and from clearing the untouched positions. Empty frames and stray clock edges outside a frame show whether idle edges leak into the shift register. The load and clear tests run with both strap settings and with the load strobe held low or pulsed. They separate a transfer at frame end from a deferred transfer, and show whether a held clear masks both kinds.

// File: rtl/dacFrontPkg.sv
package dacFrontPkg;

  typedef struct packed {
    logic shiftEn;
    logic loadInput;
    logic loadDacFromShift;
    logic loadDacFromInput;
    logic clearAll;
    logic clrLow;
  } strobeT;

endpackage

// File: rtl/dacFrontCtrl.sv
module dacFrontCtrl
  import dacFrontPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   csN,
  input  logic   sclk,
  input  logic   din,
  input  logic   ldacN,
  input  logic   clrN,
  output strobeT strb,
  output logic   dinSync,
  output logic   frameDone,
  output logic   frameFull
);

  localparam int PIN_N = 5;
  localparam int CS_I = 4, LDAC_I = 3, CLR_I = 2, SCLK_I = 1, DIN_I = 0;
  localparam logic [PIN_N-1:0] IDLE_VEC = 5'b11100;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [PIN_N-1:0] pinRaw;
  logic [PIN_N-1:0] syncPipe [SYNC_STAGES];
  logic [PIN_N-1:0] pinNow, pinPrev;
  logic [CNT_W-1:0] bitCnt;
  logic csRise, csFall, sclkRise, ldacFall, clrFall;

  assign pinRaw = {csN, ldacN, clrN, sclk, din};

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= IDLE_VEC;
        else if (s == 0) syncPipe[s] <= pinRaw;
        else syncPipe[s] <= syncPipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinNow = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= IDLE_VEC;
    else pinPrev <= pinNow;
  end

  assign csRise   =  pinNow[CS_I]   & ~pinPrev[CS_I];
  assign csFall   = ~pinNow[CS_I]   &  pinPrev[CS_I];
  assign sclkRise =  pinNow[SCLK_I] & ~pinPrev[SCLK_I];
  assign ldacFall = ~pinNow[LDAC_I] &  pinPrev[LDAC_I];
  assign clrFall  = ~pinNow[CLR_I]  &  pinPrev[CLR_I];
  assign dinSync  = pinNow[DIN_I];

  always_comb begin
    strb.shiftEn          = sclkRise & ~pinNow[CS_I];
    strb.loadInput        = csRise;
    strb.loadDacFromShift = csRise & ~pinNow[LDAC_I] & pinNow[CLR_I];
    strb.loadDacFromInput = ldacFall & pinNow[CLR_I];
    strb.clearAll         = clrFall;
    strb.clrLow           = ~pinNow[CLR_I];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (csFall) bitCnt <= '0;
    else if (strb.shiftEn && bitCnt != CNT_W'(DATA_W)) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameDone <= 1'b0;
      frameFull <= 1'b0;
    end else begin
      frameDone <= csRise;
      frameFull <= csRise && (bitCnt == CNT_W'(DATA_W));
    end
  end

  // R10
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

endmodule

// File: rtl/dacFrontData.sv
module dacFrontData
  import dacFrontPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              dinSync,
  input  logic              midClr,
  output logic [DATA_W-1:0] dacCode
);

  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] shiftReg, inputReg, dacReg, clearCode;

  assign clearCode = midClr ? MID_CODE : '0;

  always_ff @(posedge clk) begin
    if (strb.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], dinSync};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inputReg <= '0;
      dacReg   <= '0;
    end else if (strb.clearAll) begin
      inputReg <= clearCode;
      dacReg   <= clearCode;
    end else begin
      if (strb.loadInput) inputReg <= shiftReg;
      if (strb.loadDacFromShift) dacReg <= shiftReg;
      else if (strb.loadDacFromInput) dacReg <= inputReg;
    end
  end

  assign dacCode = dacReg;

  // R2
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(shiftReg));

  // R6
  clear_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (dacReg == $past(clearCode)) && (inputReg == $past(clearCode)));

  // R7
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrLow && !strb.clearAll) |=> $stable(dacReg));

  // R5
  ldac_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadDacFromInput && !strb.loadDacFromShift && !strb.clearAll)
      |=> (dacReg == $past(inputReg)));

endmodule

// File: rtl/segDecoder.sv
module segDecoder #(
  parameter int DATA_W = 16,
  parameter int MSB_W  = 4,
  localparam int SEG_N = (1 << MSB_W) - 1,
  localparam int LSB_W = DATA_W - MSB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] code,
  output logic [SEG_N-1:0]  segTherm,
  output logic [LSB_W-1:0]  ladderBits
);

  logic [MSB_W-1:0] msbVal;

  assign msbVal     = code[DATA_W-1 -: MSB_W];
  assign ladderBits = code[LSB_W-1:0];

  generate
    for (genvar i = 0; i < SEG_N; i++) begin : g_seg
      assign segTherm[i] = (msbVal > MSB_W'(i));
    end
  endgenerate

  // R9
  therm_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(segTherm) == int'(msbVal));

  // R9
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((segTherm >> 1) & ~segTherm) == '0);

endmodule

// File: rtl/dacFrontEnd.sv
module dacFrontEnd
  import dacFrontPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int MSB_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEG_N = (1 << MSB_W) - 1,
  localparam int LSB_W = DATA_W - MSB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic              ldacN,
  input  logic              clrN,
  input  logic              midClr,
  output logic [DATA_W-1:0] dacCode,
  output logic [SEG_N-1:0]  segTherm,
  output logic [LSB_W-1:0]  ladderBits,
  output logic              frameDone,
  output logic              frameFull
);

  strobeT strb;
  logic   dinSync;

  dacFrontCtrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .ldacN(ldacN), .clrN(clrN), .strb(strb), .dinSync(dinSync),
    .frameDone(frameDone), .frameFull(frameFull)
  );

  dacFrontData #(.DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .dinSync(dinSync),
    .midClr(midClr), .dacCode(dacCode)
  );

  segDecoder #(.DATA_W(DATA_W), .MSB_W(MSB_W)) seg_i (
    .clk(clk), .rstN(rstN), .code(dacCode),
    .segTherm(segTherm), .ladderBits(ladderBits)
  );

endmodule

// File: tb/dacFrontEnd_tb.sv
module dacFrontEnd_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, din = 1'b0, ldacN = 1'b1, clrN = 1'b1, midClr = 1'b0;
  logic [15:0] dacCode;
  logic [14:0] segTherm;
  logic [11:0] ladderBits;
  logic frameDone, frameFull;

  int checks = 0;
  int errors = 0;
  int donePulses = 0;
  logic lastFull = 1'b0;
  logic prevDone = 1'b0;
  logic wideSeen = 1'b0;

  always #4 clk = ~clk;

  dacFrontEnd dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .ldacN(ldacN), .clrN(clrN), .midClr(midClr), .dacCode(dacCode),
    .segTherm(segTherm), .ladderBits(ladderBits),
    .frameDone(frameDone), .frameFull(frameFull)
  );

  always @(negedge clk) begin
    if (frameDone) begin
      donePulses++;
      lastFull = frameFull;
      if (prevDone) wideSeen = 1'b1;
    end
    prevDone = frameDone;
  end

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic checkVal(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic checkCode(input string tag, input logic [15:0] exp);
    logic [14:0] expTherm;
    expTherm = 15'((32'd1 << exp[15:12]) - 1);
    checkVal({tag, " dacCode"}, 32'(dacCode), 32'(exp));
    checkVal({tag, " R9 segTherm"}, 32'(segTherm), 32'(expTherm));
    checkVal({tag, " R9 ladderBits"}, 32'(ladderBits), 32'(exp[11:0]));
  endtask

  task automatic sendBits(input logic [31:0] w, input int n);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      din = w[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic checkFrame(input string tag, input int expPulses, input logic expFull);
    checkVal({tag, " R10 pulse count"}, 32'(donePulses), 32'(expPulses));
    checkVal({tag, " R10 frameFull"}, 32'(lastFull), 32'(expFull));
  endtask

  task automatic pulseLdac;
    ldacN = 1'b0;
    repeat (8) @(negedge clk);
    ldacN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulseClr;
    clrN = 1'b0;
    repeat (8) @(negedge clk);
    clrN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] word, prev;
    int frames;
    frames = 0;

    repeat (5) @(negedge clk);
    // R8 reset state
    checkCode("R8 reset", 16'h0000);
    checkVal("R8 frameDone", 32'(frameDone), 32'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R9 / R10: full frames, top nibble swept, load strobe held low
    ldacN = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      word = {4'(k), 12'((k * 273 + 5) ^ (k << 7))};
      sendBits(32'(word), 16);
      frames++;
      checkCode("R1 full frame", word);
      checkFrame("R10 full frame", frames, 1'b1);
    end
    prev = word;

    // R3: overlong frame keeps the last 16 bits
    sendBits(32'h000A_5C3E, 20);
    frames++;
    checkCode("R3 overlong", 16'h5C3E);
    checkFrame("R3 R10 overlong", frames, 1'b1);
    prev = 16'h5C3E;

    // R4: short frame shifts the old word up
    sendBits(32'h0000_000B, 4);
    frames++;
    word = {prev[11:0], 4'hB};
    checkCode("R4 short", word);
    checkFrame("R4 R10 short", frames, 1'b0);
    prev = word;

    // R2: stray sclk edges with csN high, then an empty frame
    for (int i = 0; i < 10; i++) begin
      din = i[0];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    sendBits(32'h0, 0);
    frames++;
    checkCode("R2 idle edges", prev);
    checkFrame("R2 R10 empty", frames, 1'b0);
    checkVal("R10 single-cycle pulse", 32'(wideSeen), 32'd0);

    // R5: deferred transfer
    ldacN = 1'b1;
    repeat (4) @(negedge clk);
    sendBits(32'h0000_3A71, 16);
    frames++;
    checkCode("R5 held", prev);
    pulseLdac();
    checkCode("R5 after ldac", 16'h3A71);

    // R6: clear to midscale, then zero-scale
    midClr = 1'b1;
    pulseClr();
    checkCode("R6 mid clear", 16'h8000);
    pulseLdac();
    checkCode("R6 input cleared mid", 16'h8000);
    midClr = 1'b0;
    sendBits(32'h0000_E0F1, 16);
    frames++;
    pulseLdac();
    checkCode("R5 second load", 16'hE0F1);
    pulseClr();
    checkCode("R6 zero clear", 16'h0000);
    pulseLdac();
    checkCode("R6 input cleared zero", 16'h0000);

    // R7: clear held low masks loads, input register still captures
    sendBits(32'h0000_4242, 16);
    frames++;
    pulseLdac();
    checkCode("R5 pre-clear load", 16'h4242);
    clrN = 1'b0;
    repeat (8) @(negedge clk);
    checkCode("R7 clear taken", 16'h0000);
    sendBits(32'h0000_9D2C, 16);
    frames++;
    pulseLdac();
    checkCode("R7 ldac masked", 16'h0000);
    ldacN = 1'b0;
    repeat (4) @(negedge clk);
    sendBits(32'h0000_71B5, 16);
    frames++;
    checkCode("R7 frame-end load masked", 16'h0000);
    checkFrame("R7 R10 during clear", frames, 1'b1);
    ldacN = 1'b1;
    repeat (8) @(negedge clk);
    clrN = 1'b1;
    repeat (8) @(negedge clk);
    checkCode("R7 release no change", 16'h0000);
    pulseLdac();
    checkCode("R7 input kept frame", 16'h71B5);

    finishRun();
  end

endmodule